// File: doc/BRIEF.md
# Serial Configuration Memory and PHY Management Sequencer

This block lets software reach two slow targets through one small register window: a 64-word by 16-bit three-wire serial EEPROM and the management registers of an Ethernet PHY. Software places a word address (or a PHY address and register number) in an address register, and 16 bits of data in a low-byte and a high-byte register. It then writes a command byte. The block raises a busy flag, runs the access and drops busy when the result is in the data registers. Software polls busy and then writes the command register again to clear the command.

EEPROM traffic is a single chip-select frame. It carries a start bit, a two-bit opcode and a six-bit word address, followed by sixteen data bits, most significant bit first. PHY traffic is a one-cycle request on a simple internal register port. A reload command reads the first configuration words of the EEPROM in ascending order and offers each one on a dedicated output port.

Top module: `serialCfgPort`

## Requirements
- R1: After reset every register reads 0x00, busy is 0, the EEPROM chip select and serial clock are low and no PHY request is raised.
- R2: Registers are located at fixed indices. Index 0x0C is the address, 0x0D is data bits 7:0 and 0x0E is data bits 15:8. Index 0x0B is the command, which reads back as {2'b00, stored bits 5:1, busy in bit 0}. The command bits are: bit 1 write, bit 2 read, bit 3 target (0 EEPROM, 1 PHY), bit 4 EEPROM write enable and bit 5 reload.
- R3: An EEPROM read (command 0x04) raises chip select and shifts out on DI a start bit 1, then opcode 10, then the address bits 5:0, with the MSB first. It then samples 16 bits from DO on the following rising serial-clock edges, MSB first, and places the word in the data registers. DI changes only while the serial clock is low.
- R4: The serial clock has a half period of CLK_DIV cycles. An EEPROM read keeps busy high for exactly 1 + 50*CLK_DIV cycles.
- R5: An EEPROM write (command 0x12) sends a start bit 1, then opcode 01, then the address and then the 16 data bits, MSB first. Busy then stays high for a further WR_WAIT cycles with chip select low.
- R6: An EEPROM write command without bit 4 set is ignored. Busy never rises and no frame is sent.
- R7: A PHY command (bit 3 set) issues a one-cycle request with the register number taken from address bits 4:0. A read (0x0C) loads the returned word into the data registers, and a write (0x0A) sends the data registers. Busy is high for exactly one cycle. If address bits 7:6 are not 01, the command is ignored.
- R8: While busy is high, writes to the command, address and data registers are ignored.
- R9: Reload (bit 5, which takes priority over read and write) reads EEPROM words 0 to CFG_WORDS-1 in order. Each word is presented for one cycle on the configuration output. The data registers are left unchanged. Chip select stays low for at least 2*CLK_DIV cycles between frames.
- R10: A command value with none of bits 1, 2 or 5 set (for example 0x08) is only stored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Register write strobe |
| hostAddr | input | 8 | Register index |
| hostWrData | input | 8 | Register write byte |
| hostRdData | output | 8 | Register read byte for hostAddr (combinational) |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |
| phyReq | output | 1 | One-cycle PHY access request |
| phyWrite | output | 1 | PHY access is a write |
| phyRegNum | output | 5 | PHY register number |
| phyWrData | output | 16 | PHY write word |
| phyRdData | input | 16 | PHY read word, sampled during phyReq |
| cfgValid | output | 1 | Reloaded configuration word is valid |
| cfgIdx | output | 6 | Index of the reloaded word |
| cfgData | output | 16 | Reloaded word |

## Verification
Busy is visible in the cycle after the command write. It stays high for 1 + 50*CLK_DIV cycles for a read and for WR_WAIT more cycles for a write, but for only one cycle on a PHY access. The bench counts busy cycles sample by sample at the falling clock edge and compares each count with those formulas. Data registers and command readback are checked only after busy has fallen. Reloaded words are captured as they appear, which is one cycle after each frame closes. Ignored commands are checked in the very next sample: busy must be low and the EEPROM frame count must not change.

// File: rtl/scfgPkg.sv
package scfgPkg;
  localparam logic [7:0] REG_CMD  = 8'h0B;
  localparam logic [7:0] REG_ADDR = 8'h0C;
  localparam logic [7:0] REG_DLO  = 8'h0D;
  localparam logic [7:0] REG_DHI  = 8'h0E;

  localparam int B_WRITE  = 1;
  localparam int B_READ   = 2;
  localparam int B_PHY    = 3;
  localparam int B_WREN   = 4;
  localparam int B_RELOAD = 5;

  localparam logic [1:0] PHY_ID   = 2'b01;
  localparam int         HDR_LEN  = 9;
  localparam int         FRAME_LEN = 25;

  typedef struct packed {
    logic        frameStart;
    logic        frameWrite;
    logic [5:0]  frameAddr;
    logic [15:0] frameData;
  } frameStrb_t;

  typedef enum logic [2:0] {ST_IDLE, ST_LAUNCH, ST_FRAME, ST_WAIT, ST_PHY} state_t;
  typedef enum logic [1:0] {MD_READ, MD_WRITE, MD_RELOAD} mode_t;
endpackage

// File: rtl/scfgSerial.sv
module scfgSerial
  import scfgPkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  frameStrb_t strb,
  input  logic       eeDo,
  output logic       eeCs,
  output logic       eeSk,
  output logic       eeDi,
  output logic       frameDone,
  output logic [15:0] rdWord
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [FRAME_LEN-1:0] outSh;
  logic [15:0]          inSh;
  logic [4:0]           riseCnt;
  logic [DIV_W-1:0]     divCnt;
  logic                 tick;

  assign tick      = eeCs && (divCnt == '0);
  assign frameDone = tick && eeSk && (riseCnt == 5'(FRAME_LEN));
  assign eeDi      = eeCs & outSh[FRAME_LEN-1];
  assign rdWord    = inSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eeCs    <= 1'b0;
      eeSk    <= 1'b0;
      outSh   <= '0;
      inSh    <= '0;
      riseCnt <= '0;
      divCnt  <= '0;
    end else if (strb.frameStart) begin
      eeCs    <= 1'b1;
      eeSk    <= 1'b0;
      riseCnt <= '0;
      divCnt  <= DIV_W'(CLK_DIV - 1);
      outSh   <= {1'b1, (strb.frameWrite ? 2'b01 : 2'b10), strb.frameAddr,
                  (strb.frameWrite ? strb.frameData : 16'h0000)};
    end else if (eeCs) begin
      if (tick) begin
        divCnt <= DIV_W'(CLK_DIV - 1);
        if (!eeSk) begin
          eeSk    <= 1'b1;
          riseCnt <= riseCnt + 5'd1;
          if (riseCnt >= 5'(HDR_LEN)) inSh <= {inSh[14:0], eeDo};
        end else begin
          eeSk  <= 1'b0;
          outSh <= {outSh[FRAME_LEN-2:0], 1'b0};
          if (riseCnt == 5'(FRAME_LEN)) eeCs <= 1'b0;
        end
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  // R3: the serial clock only toggles inside a frame
  p_sk_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);
  // R3: data to the EEPROM holds while the serial clock is high
  p_di_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));
  // R4: a frame never runs past its bit count
  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= 5'(FRAME_LEN));
  // R9: a new frame is only launched with chip select low
  p_launch_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |-> !eeCs);
endmodule

// File: rtl/scfgCtrl.sv
module scfgCtrl
  import scfgPkg::*;
#(
  parameter int CFG_WORDS = 8,
  parameter int WR_WAIT   = 64,
  parameter int GAP       = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [7:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  logic        frameDone,
  input  logic [15:0] rdWord,
  output frameStrb_t  strb,
  output logic        phyReq,
  output logic        phyWrite,
  output logic [4:0]  phyRegNum,
  output logic [15:0] phyWrData,
  input  logic [15:0] phyRdData,
  output logic        cfgValid,
  output logic [5:0]  cfgIdx,
  output logic [15:0] cfgData
);
  localparam int WAIT_MAX = (WR_WAIT > GAP) ? WR_WAIT : GAP;
  localparam int WW       = $clog2(WAIT_MAX + 1);

  state_t      state;
  mode_t       mode;
  logic [7:0]  addrReg, dataLo, dataHi;
  logic [4:0]  cmdBits;
  logic [5:0]  wordIdx;
  logic        opWrite;
  logic [WW-1:0] waitCnt;
  logic        busy, cmdWr, phyOk, lastWord;

  assign busy     = (state != ST_IDLE);
  assign cmdWr    = hostWe && (hostAddr == REG_CMD) && !busy;
  assign phyOk    = (addrReg[7:6] == PHY_ID);
  assign lastWord = (wordIdx == 6'(CFG_WORDS - 1));

  always_comb begin
    strb.frameStart = (state == ST_LAUNCH);
    strb.frameWrite = (mode == MD_WRITE);
    strb.frameAddr  = (mode == MD_RELOAD) ? wordIdx : addrReg[5:0];
    strb.frameData  = {dataHi, dataLo};
  end

  assign phyReq    = (state == ST_PHY);
  assign phyWrite  = opWrite;
  assign phyRegNum = addrReg[4:0];
  assign phyWrData = {dataHi, dataLo};

  always_comb begin
    case (hostAddr)
      REG_CMD:  hostRdData = {2'b00, cmdBits, busy};
      REG_ADDR: hostRdData = addrReg;
      REG_DLO:  hostRdData = dataLo;
      REG_DHI:  hostRdData = dataHi;
      default:  hostRdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mode     <= MD_READ;
      addrReg  <= '0;
      dataLo   <= '0;
      dataHi   <= '0;
      cmdBits  <= '0;
      wordIdx  <= '0;
      opWrite  <= 1'b0;
      waitCnt  <= '0;
      cfgValid <= 1'b0;
      cfgIdx   <= '0;
      cfgData  <= '0;
    end else begin
      cfgValid <= 1'b0;
      if (hostWe && !busy) begin
        if (hostAddr == REG_ADDR) addrReg <= hostWrData;
        if (hostAddr == REG_DLO)  dataLo  <= hostWrData;
        if (hostAddr == REG_DHI)  dataHi  <= hostWrData;
      end
      case (state)
        ST_IDLE: if (cmdWr) begin
          cmdBits <= hostWrData[5:1];
          if (hostWrData[B_RELOAD]) begin
            mode <= MD_RELOAD; wordIdx <= '0; state <= ST_LAUNCH;
          end else if (hostWrData[B_READ]) begin
            if (!hostWrData[B_PHY]) begin
              mode <= MD_READ; state <= ST_LAUNCH;
            end else if (phyOk) begin
              opWrite <= 1'b0; state <= ST_PHY;
            end
          end else if (hostWrData[B_WRITE]) begin
            if (!hostWrData[B_PHY]) begin
              if (hostWrData[B_WREN]) begin
                mode <= MD_WRITE; state <= ST_LAUNCH;
              end
            end else if (phyOk) begin
              opWrite <= 1'b1; state <= ST_PHY;
            end
          end
        end
        ST_LAUNCH: state <= ST_FRAME;
        ST_FRAME: if (frameDone) begin
          case (mode)
            MD_READ: begin
              {dataHi, dataLo} <= rdWord;
              state <= ST_IDLE;
            end
            MD_WRITE: begin
              waitCnt <= WW'(WR_WAIT - 1);
              state   <= ST_WAIT;
            end
            default: begin
              cfgValid <= 1'b1;
              cfgIdx   <= wordIdx;
              cfgData  <= rdWord;
              waitCnt  <= WW'(GAP - 1);
              state    <= ST_WAIT;
            end
          endcase
        end
        ST_WAIT: begin
          if (waitCnt == '0) begin
            if (mode == MD_RELOAD && !lastWord) begin
              wordIdx <= wordIdx + 6'd1;
              state   <= ST_LAUNCH;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_PHY: begin
          if (!opWrite) {dataHi, dataLo} <= phyRdData;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a PHY request lasts a single cycle
  p_phy_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    phyReq |=> !phyReq);
  // R8: a command written while busy leaves the stored command alone
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == REG_CMD && busy) |=> $stable(cmdBits));
  // R8: address writes while busy are dropped
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == REG_ADDR && busy) |=> $stable(addrReg));
  // R6: an EEPROM write without enable never raises busy
  p_no_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && hostWrData[B_WRITE] && !hostWrData[B_READ] && !hostWrData[B_RELOAD]
     && !hostWrData[B_PHY] && !hostWrData[B_WREN]) |=> !busy);
  // R9: reloaded indices stay inside the configuration window
  p_reload_idx_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (int'(cfgIdx) < CFG_WORDS));
endmodule

// File: rtl/serialCfgPort.sv
module serialCfgPort
  import scfgPkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter int WR_WAIT   = 64,
  parameter int CFG_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [7:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo,
  output logic        phyReq,
  output logic        phyWrite,
  output logic [4:0]  phyRegNum,
  output logic [15:0] phyWrData,
  input  logic [15:0] phyRdData,
  output logic        cfgValid,
  output logic [5:0]  cfgIdx,
  output logic [15:0] cfgData
);
  localparam int GAP = 2 * CLK_DIV;

  frameStrb_t  strb;
  logic        frameDone;
  logic [15:0] rdWord;

  scfgCtrl #(.CFG_WORDS(CFG_WORDS), .WR_WAIT(WR_WAIT), .GAP(GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .frameDone(frameDone),
    .rdWord(rdWord), .strb(strb), .phyReq(phyReq), .phyWrite(phyWrite),
    .phyRegNum(phyRegNum), .phyWrData(phyWrData), .phyRdData(phyRdData),
    .cfgValid(cfgValid), .cfgIdx(cfgIdx), .cfgData(cfgData)
  );

  scfgSerial #(.CLK_DIV(CLK_DIV)) uSerial (
    .clk(clk), .rstN(rstN), .strb(strb), .eeDo(eeDo), .eeCs(eeCs),
    .eeSk(eeSk), .eeDi(eeDi), .frameDone(frameDone), .rdWord(rdWord)
  );
endmodule

// File: tb/serialCfgPort_test.sv
module eeModel (
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic [15:0] mem [64];
  logic [8:0]  hdr;
  logic [15:0] wbuf, rsh;
  logic        rdMode;
  logic [1:0]  lastOp;
  logic [5:0]  lastAddr;
  int          bitCnt;
  int          frames;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'hC0DE ^ (16'(i) * 16'h0403);
    dout = 1'b0; frames = 0; bitCnt = 0; rdMode = 1'b0;
    hdr = '0; wbuf = '0; rsh = '0; lastOp = '0; lastAddr = '0;
  end

  always @(posedge cs) begin bitCnt = 0; rdMode = 1'b0; end

  always @(posedge sk) if (cs) begin
    if (bitCnt < 9) hdr = {hdr[7:0], di};
    else if (bitCnt < 25) wbuf = {wbuf[14:0], di};
    bitCnt++;
    if (bitCnt == 9) begin
      lastOp = hdr[7:6]; lastAddr = hdr[5:0];
      if (hdr[8] && hdr[7:6] == 2'b10) begin rdMode = 1'b1; rsh = mem[hdr[5:0]]; end
    end
  end

  always @(negedge sk) if (cs && rdMode) begin
    dout = rsh[15]; rsh = {rsh[14:0], 1'b0};
  end

  always @(negedge cs) begin
    frames++;
    if (bitCnt == 25 && hdr[8] && hdr[7:6] == 2'b01) mem[hdr[5:0]] = wbuf;
    dout = 1'b0;
  end
endmodule

module serialCfgPort_test;
  localparam int H  = 2;
  localparam int WW = 20;
  localparam int NW = 4;

  logic clk = 1'b0, rstN = 1'b0, hostWe = 1'b0;
  logic [7:0] hostAddr = 8'h00, hostWrData = 8'h00, hostRdData;
  logic eeCs, eeSk, eeDi, eeDo;
  logic phyReq, phyWrite;
  logic [4:0] phyRegNum;
  logic [15:0] phyWrData, phyRdData;
  logic cfgValid;
  logic [5:0] cfgIdx;
  logic [15:0] cfgData;

  always #4 clk = ~clk;

  serialCfgPort #(.CLK_DIV(H), .WR_WAIT(WW), .CFG_WORDS(NW)) uut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .eeDo(eeDo), .phyReq(phyReq), .phyWrite(phyWrite),
    .phyRegNum(phyRegNum), .phyWrData(phyWrData), .phyRdData(phyRdData),
    .cfgValid(cfgValid), .cfgIdx(cfgIdx), .cfgData(cfgData)
  );

  eeModel mdl (.cs(eeCs), .sk(eeSk), .di(eeDi), .dout(eeDo));

  logic [15:0] phyMem [32];
  logic [15:0] expEe  [64];
  logic [15:0] expPhy [32];
  assign phyRdData = phyMem[phyRegNum];
  always @(posedge clk) if (phyReq && phyWrite) phyMem[phyRegNum] <= phyWrData;

  int errors = 0, checks = 0;
  int capN = 0;
  logic [5:0]  capIdx [16];
  logic [15:0] capData [16];
  always @(posedge clk) if (cfgValid && capN < 16) begin
    capIdx[capN] = cfgIdx; capData[capN] = cfgData; capN++;
  end

  int lowRun = 0, minGap = 1000;
  bit seenFrame = 1'b0;
  always @(posedge clk) begin
    if (!eeCs) lowRun++;
    else if (lowRun > 0) begin
      if (seenFrame && lowRun < minGap) minGap = lowRun;
      seenFrame = 1'b1; lowRun = 0;
    end
  end

  typedef struct packed { logic [7:0] cmd; logic [7:0] adr; logic [15:0] dat; } vec_t;
  localparam vec_t VECS [12] = '{
    '{8'h12, 8'h05, 16'h1234}, '{8'h04, 8'h05, 16'h0000},
    '{8'h04, 8'h00, 16'hFFFF}, '{8'h04, 8'h3F, 16'h0101},
    '{8'h0A, 8'h43, 16'hBEEF}, '{8'h0C, 8'h43, 16'h0000},
    '{8'h0C, 8'h5F, 16'h7777}, '{8'h12, 8'h3F, 16'h8001},
    '{8'h04, 8'h3F, 16'h0000}, '{8'h02, 8'h07, 16'h0000},
    '{8'h04, 8'h07, 16'h5555}, '{8'h0C, 8'h83, 16'h6A6A}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    hostAddr = a; #1; v = hostRdData;
  endtask

  task automatic busyCount(output int n);
    logic [7:0] v;
    n = 0;
    rd(8'h0B, v);
    while (v[0] && n < 5000) begin
      n++; @(negedge clk); rd(8'h0B, v);
    end
  endtask

  task automatic readData(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(8'h0D, lo); rd(8'h0E, hi); w = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    int n, fr;
    for (int i = 0; i < 32; i++) begin
      phyMem[i] = 16'h1000 + 16'(i) * 16'd3; expPhy[i] = phyMem[i];
    end
    for (int i = 0; i < 64; i++) expEe[i] = 16'hC0DE ^ (16'(i) * 16'h0403);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h0B, v); chk(v == 8'h00, "R1 cmd", v, 0);
    rd(8'h0C, v); chk(v == 8'h00, "R1 addr", v, 0);
    readData(w);  chk(w == 16'h0000, "R1 data", w, 0);
    chk({eeCs, eeSk, phyReq} == 3'b000, "R1 pins", {eeCs, eeSk, phyReq}, 0);

    // R2: register readback
    wr(8'h0C, 8'h9C); rd(8'h0C, v); chk(v == 8'h9C, "R2 addr", v, 8'h9C);
    wr(8'h0D, 8'h3E); wr(8'h0E, 8'hC1); readData(w);
    chk(w == 16'hC13E, "R2 data", w, 16'hC13E);

    // R10: command with no start bits only stored
    fr = mdl.frames;
    wr(8'h0B, 8'h08); rd(8'h0B, v);
    chk(v == 8'h08, "R10 store", v, 8'h08);
    chk(mdl.frames == fr && !phyReq, "R10 nothing started", mdl.frames, fr);
    wr(8'h0B, 8'h00);

    // vector table walk (R3, R5, R6, R7)
    foreach (VECS[k]) begin
      automatic vec_t t = VECS[k];
      automatic bit isPhy = t.cmd[3];
      automatic bit ign = isPhy ? (t.adr[7:6] != 2'b01) : (t.cmd[1] && !t.cmd[2] && !t.cmd[4]);
      wr(8'h0C, t.adr); wr(8'h0D, t.dat[7:0]); wr(8'h0E, t.dat[15:8]);
      fr = mdl.frames;
      wr(8'h0B, t.cmd);
      rd(8'h0B, v);
      chk(v[0] == !ign, isPhy ? "R7 busy start" : (ign ? "R6 ignored" : "R3 busy start"), v[0], !ign);
      busyCount(n);
      if (ign && !isPhy) chk(mdl.frames == fr, "R6 no frame", mdl.frames, fr);
      if (isPhy && !ign) chk(n == 1, "R7 busy one cycle", n, 1);
      readData(w);
      if (t.cmd[2]) begin
        if (ign) chk(w == t.dat, "R7 bad phy id keeps data", w, t.dat);
        else if (isPhy) chk(w == expPhy[t.adr[4:0]], "R7 phy read", w, expPhy[t.adr[4:0]]);
        else chk(w == expEe[t.adr[5:0]], "R3 ee read", w, expEe[t.adr[5:0]]);
      end else if (!ign) begin
        if (isPhy) expPhy[t.adr[4:0]] = t.dat; else expEe[t.adr[5:0]] = t.dat;
      end
      rd(8'h0B, v); chk(v == (t.cmd & 8'h3E), "R2 cmd readback", v, t.cmd & 8'h3E);
      wr(8'h0B, 8'h00);
    end

    // R3: header content and R4: read busy length
    wr(8'h0C, 8'h2B); wr(8'h0B, 8'h04); busyCount(n);
    chk(n == 1 + 50 * H, "R4 read busy cycles", n, 1 + 50 * H);
    chk(mdl.lastOp == 2'b10 && mdl.lastAddr == 6'h2B, "R3 header", {mdl.lastOp, mdl.lastAddr}, {2'b10, 6'h2B});
    readData(w); chk(w == expEe[6'h2B], "R3 read word", w, expEe[6'h2B]);
    wr(8'h0B, 8'h00);

    // R5: write busy length and header
    wr(8'h0C, 8'h11); wr(8'h0D, 8'hA0); wr(8'h0E, 8'h0F);
    wr(8'h0B, 8'h12); busyCount(n); expEe[6'h11] = 16'h0FA0;
    chk(n == 1 + 50 * H + WW, "R5 write busy cycles", n, 1 + 50 * H + WW);
    chk(mdl.lastOp == 2'b01 && mdl.lastAddr == 6'h11, "R5 header", {mdl.lastOp, mdl.lastAddr}, {2'b01, 6'h11});
    chk(mdl.mem[6'h11] == 16'h0FA0, "R5 stored word", mdl.mem[6'h11], 16'h0FA0);
    wr(8'h0B, 8'h00);

    // R8: writes while busy ignored
    wr(8'h0C, 8'h09); wr(8'h0B, 8'h04);
    wr(8'h0C, 8'h03); wr(8'h0B, 8'h0A); wr(8'h0D, 8'h77);
    rd(8'h0B, v); chk(v == 8'h05, "R8 cmd unchanged", v, 8'h05);
    busyCount(n);
    rd(8'h0C, v); chk(v == 8'h09, "R8 addr unchanged", v, 8'h09);
    readData(w); chk(w == expEe[9], "R8 original read", w, expEe[9]);
    wr(8'h0B, 8'h00);

    // R9: reload with priority over read
    wr(8'h0D, 8'h5A); wr(8'h0E, 8'hA5);
    capN = 0; minGap = 1000; seenFrame = 1'b0;
    wr(8'h0B, 8'h24); busyCount(n);
    @(negedge clk);
    chk(capN == NW, "R9 word count", capN, NW);
    for (int i = 0; i < NW; i++)
      chk(capIdx[i] == 6'(i) && capData[i] == expEe[i], "R9 word", capData[i], expEe[i]);
    readData(w); chk(w == 16'hA55A, "R9 data untouched", w, 16'hA55A);
    chk(minGap >= 2 * H, "R9 cs gap", minGap, 2 * H);
    wr(8'h0B, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule